// File: doc/BRIEF.md
# Prioritized Four-Way Shift Register

This block is a register of parameterized width (four bits by default). Each clock edge it holds its value, loads a parallel word, shifts toward the least significant end or shifts toward the most significant end. Three independent request lines select the operation: load, shift right and shift left. A fixed priority encoder folds them into a 2-bit mode code, and that code steers one four-input multiplexer in front of each flip-flop.

Load outranks both shifts. A right shift outranks a left shift. With no request raised, the register keeps its contents. A synchronous reset clears the register and overrides every request. The block fits a datapath that needs serial conversion or multiply and divide by two on a stored word.

Top module: `prio_shreg`

## Requirements
- R1: While rst is high at a rising clk edge, q becomes all zeros, whatever the request and data inputs are.
- R2: With load, shift_r and shift_l all low, q keeps its value across a clock edge.
- R3: With load high, q takes din on the next edge, whatever shift_r and shift_l are.
- R4: With load low and shift_r high, q shifts one place toward bit 0 on the next edge. ser_r enters at bit WIDTH-1, and this holds whatever shift_l is.
- R5: With load and shift_r low and shift_l high, q shifts one place toward bit WIDTH-1 on the next edge, and ser_l enters at bit 0.
- R6: The mode code mode[1:0] is 00 for hold, 01 for load, 10 for shift right and 11 for shift left. It follows the fixed priority load > shift right > shift left.
- R7: q changes only at a rising clk edge. Input changes between edges leave q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load request (highest priority) |
| shift_r | input | 1 | Shift-toward-LSB request |
| shift_l | input | 1 | Shift-toward-MSB request (lowest priority) |
| ser_r | input | 1 | Serial bit entering the MSB on a right shift |
| ser_l | input | 1 | Serial bit entering the LSB on a left shift |
| din | input | WIDTH | Parallel load word |
| mode | output | 2 | Encoded operation for the current requests |
| q | output | WIDTH | Register contents |

## Verification
The mode code is combinational, so it is due in the same cycle as the requests. The bench checks it a few nanoseconds after driving them, before the next edge. Every register result is due one edge after its requests. The bench drives the inputs on the falling edge, computes the expected word from the value it last saw on q, and compares q just after the following rising edge. A mid-cycle input change is also made and q is checked before the edge, which confirms that no value moves early.

// File: rtl/prio_shreg.sv
module prio_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift_r,
  input  logic             shift_l,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] din,
  output logic [1:0]       mode,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nxt;

  assign mode[1] = ~load & (shift_r | shift_l);
  assign mode[0] = load | (~shift_r & shift_l);

  always_comb begin
    case (mode)
      2'b01:   nxt = din;
      2'b10:   nxt = {ser_r, q[WIDTH-1:1]};
      2'b11:   nxt = {q[WIDTH-2:0], ser_l};
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

module prio_shreg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             shift_r,
  input logic             shift_l,
  input logic             ser_r,
  input logic             ser_l,
  input logic [WIDTH-1:0] din,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> q == '0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift_r && !shift_l) |=> $stable(q));
  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));
  // R4
  shr_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_r) |=> q == {$past(ser_r), $past(q[WIDTH-1:1])});
  // R5
  shl_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift_r && shift_l) |=> q == {$past(q[WIDTH-2:0]), $past(ser_l)});
  // R6
  mode_chk: assert property (@(posedge clk)
    mode == (load ? 2'b01 : shift_r ? 2'b10 : shift_l ? 2'b11 : 2'b00));
endmodule

bind prio_shreg prio_shreg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/prio_shreg_bench.sv
module prio_shreg_bench;
  localparam int W = 4;
  logic clk = 0, rst = 1, load = 0, shift_r = 0, shift_l = 0, ser_r = 0, ser_l = 0;
  logic [W-1:0] din = '0;
  logic [1:0] mode;
  logic [W-1:0] q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_shreg #(.WIDTH(W)) u_prio_shreg (.*);

  function automatic logic [1:0] exp_mode(logic l, logic r, logic s);
    return l ? 2'b01 : r ? 2'b10 : s ? 2'b11 : 2'b00;
  endfunction

  function automatic logic [W-1:0] exp_q(logic [W-1:0] cur, logic l, logic r, logic s,
                                         logic sr, logic sl, logic [W-1:0] d);
    if (l) return d;
    if (r) return {sr, cur[W-1:1]};
    if (s) return {cur[W-2:0], sl};
    return cur;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic l, logic r, logic s, logic sr, logic sl, logic [W-1:0] d);
    logic [W-1:0] e;
    @(negedge clk);
    load = l; shift_r = r; shift_l = s; ser_r = sr; ser_l = sl; din = d;
    #1;
    chk("R6 mode", {2'b0, mode}, {2'b0, exp_mode(l, r, s)});
    e = exp_q(q, l, r, s, sr, sl, d);
    @(posedge clk); #1;
    if (l)      chk("R3 load", q, e);
    else if (r) chk("R4 shift right", q, e);
    else if (s) chk("R5 shift left", q, e);
    else        chk("R2 hold", q, e);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] snap;
    process::self().srandom(7);
    load = 1; din = 4'hF;
    @(posedge clk); #1;
    chk("R1 reset", q, '0);
    @(negedge clk); rst = 0; load = 0;
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 2; b++) begin
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1011);
        step(c[2], c[1], c[0], b[0], ~b[0], 4'b0110);
      end
    end
    step(1, 0, 0, 0, 0, 4'b1001);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 0, 4'b0);
    chk("R4 ones filled", q, 4'b1111);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 4'b0);
    chk("R5 zeros filled", q, 4'b0000);
    @(negedge clk);
    snap = q;
    load = 1; din = 4'b0101; #1;
    chk("R7 no early change", q, snap);
    din = 4'b1100; #0.5;
    chk("R7 no early change", q, snap);
    @(posedge clk); #1;
    chk("R7 latest data at edge", q, 4'b1100);
    for (int i = 0; i < 300; i++) begin
      int r = $urandom;
      step(r[0], r[1], r[2], r[3], r[4], W'(r[8:5]));
    end
    @(negedge clk);
    rst = 1; load = 1; shift_r = 1; din = 4'hA;
    @(posedge clk); #1;
    chk("R1 reset overrides", q, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule